// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory of 2048 bytes. It runs on a fast system clock and oversamples the serial clock and data lines. Both lines pass through a synchroniser first. The block then detects START and STOP conditions and shifts in the header byte and the word-address byte. It drives the acknowledge bit and the read data through an active-low open-drain enable. It also keeps an 11-bit word-address counter that survives between transactions.

Each received data byte is stored in an internal register file. The same byte is also handed to an external write controller as a single-cycle strobe, together with its target address. While that controller reports busy, the engine leaves every header byte unacknowledged. This lets the bus master poll until the controller has finished.

The state machine has these states:
- `ST_IDLE`: waits for a START.
- `ST_DEV`: shifts in the header byte.
- `ST_DEV_ACK`: acknowledges the header.
- `ST_WADDR` and `ST_WADDR_ACK`: shift in and acknowledge the word address.
- `ST_WDATA` and `ST_WDATA_ACK`: shift in and acknowledge a data byte.
- `ST_RDATA`: shifts a read byte out.
- `ST_RACK`: samples the master's acknowledge.

Every change of state happens on a falling serial-clock edge, except two: a START sends any state to `ST_DEV`, and a STOP sends any state to `ST_IDLE`. The header decision at the end of `ST_DEV` goes to `ST_DEV_ACK` or back to `ST_IDLE`. The end of `ST_DEV_ACK` goes to `ST_RDATA` or `ST_WADDR`, depending on the direction bit. The end of `ST_RACK` goes to `ST_RDATA` when the master acknowledged and to `ST_IDLE` when it did not.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) is honoured in every state. It discards any partly received byte, including a partial word address, and starts a new header byte.
- R2: A rising SDA while SCL is high (STOP) returns the engine to idle with SDA released. A data byte cut short by STOP is neither stored nor strobed.
- R3: The header byte is sent MSB first. Its bits [7:4] must be 4'b1010, bits [3:1] are page bits, and bit [0] is the direction (1 = read). On a match the slave pulls SDA low for the ninth clock. On a mismatch it does not acknowledge and ignores the bus until the next START.
- R4: While `wr_busy` is high, no header byte is acknowledged.
- R5: In a write header, the page bits become address bits [10:8], and the next byte (acknowledged) becomes address bits [7:0].
- R6: Every data byte in a write is acknowledged. It produces exactly one `wr_valid` pulse carrying its address and data, and it is written to the register file.
- R7: After each written byte, the address bits [3:0] increment modulo 16 while bits [10:4] are kept. A write that runs past a 16-byte page therefore wraps to the start of the same page.
- R8: Read data is shifted out MSB first and changes only after a falling SCL. Each byte read advances the counter by one, wrapping from 0x7FF to 0x000. The page bits of a read header are ignored.
- R9: A read continues with the next byte while the master acknowledges. A master NACK ends it and releases SDA.
- R10: The counter holds the last accessed address plus one and keeps it across transactions. A header with no data followed by a repeated START in read direction gives a random read.
- R11: After reset, SDA is released, `wr_valid` is low and the counter is 0. The register file reads back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| wr_busy | input | 1 | External write controller busy; suppresses header acknowledge |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 11 | Address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |

## Verification
The assertions assume that SDA changes only while SCL is low, apart from deliberate START and STOP conditions. They also assume that every SCL level lasts longer than the synchroniser latency, so that each edge is seen exactly once. The stimulus keeps within these limits with a bit-banged master. It holds each quarter of a bit for eight system clocks and moves SDA only in the low phase, except when it forms START or STOP. The reference model tracks the memory contents, the address counter and the expected write strobes. It checks every strobe on the clock on which it appears.

// File: rtl/twi_mem_slave_pkg.sv
package twi_mem_slave_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tms_state_t;

    localparam logic [3:0] HDR_TAG = 4'b1010;
    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/tms_line_sync.sv
module tms_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_val
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic scl_s, sda_s, scl_d, sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_in;
                    sda_chain <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[STAGES-2:0], scl_in};
                    sda_chain <= {sda_chain[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    assign sda_val   = sda_s;

endmodule

// File: rtl/tms_regfile.sv
module tms_regfile #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tms_ctrl.sv
module tms_ctrl
    import twi_mem_slave_pkg::*;
#(
    parameter int AW        = 11,
    parameter int PAGE_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          sda_val,
    input  logic          busy,
    input  logic [7:0]    rd_byte,
    output logic [AW-1:0] mem_addr,
    output logic          sda_drive_low,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    localparam int HI = AW - 8;
    localparam int PB = PAGE_BITS;

    tms_state_t      state, state_nx;
    logic [3:0]      bcnt;
    logic [7:0]      shreg;
    logic [7:0]      obuf;
    logic [HI-1:0]   page_hi;
    logic [AW-1:0]   addr;
    logic            rw;
    logic            mack;
    logic            wr_valid_q;
    logic [AW-1:0]   wr_addr_q;
    logic [7:0]      wr_data_q;
    logic            byte_full;
    logic            cond;
    logic            rx_state;
    logic            rd_load;

    assign byte_full = (bcnt == 4'd8);
    assign cond      = start_det | stop_det;
    assign rx_state  = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_WDATA);
    assign rd_load   = scl_fall && !cond &&
                       (((state == ST_DEV_ACK) && rw) || ((state == ST_RACK) && mack));

    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_DEV;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_DEV:       if (scl_fall && byte_full)
                                  state_nx = (shreg[7:4] == HDR_TAG && !busy) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) state_nx = rw ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (scl_fall && byte_full) state_nx = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_full) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_full) state_nx = ST_RACK;
                ST_RACK:      if (scl_fall) state_nx = mack ? ST_RDATA : ST_IDLE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bcnt       <= '0;
            shreg      <= '0;
            obuf       <= 8'hFF;
            page_hi    <= '0;
            addr       <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            wr_valid_q <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else begin
            state      <= state_nx;
            wr_valid_q <= 1'b0;
            if (cond) begin
                bcnt <= '0;
            end else begin
                if (scl_rise && rx_state && !byte_full) begin
                    shreg <= {shreg[6:0], sda_val};
                    bcnt  <= bcnt + 4'd1;
                end
                if (scl_rise && state == ST_RDATA && !byte_full)
                    bcnt <= bcnt + 4'd1;
                if (scl_rise && state == ST_RACK)
                    mack <= ~sda_val;
                if (rd_load) begin
                    obuf <= rd_byte;
                    addr <= addr + 1'b1;
                end
                if (scl_fall) begin
                    case (state)
                        ST_DEV: if (byte_full) begin
                            bcnt <= '0;
                            rw   <= shreg[0];
                            if (!shreg[0]) page_hi <= shreg[HI:1];
                        end
                        ST_DEV_ACK:   bcnt <= '0;
                        ST_WADDR: if (byte_full) begin
                            bcnt <= '0;
                            addr <= {page_hi, shreg};
                        end
                        ST_WADDR_ACK: bcnt <= '0;
                        ST_WDATA: if (byte_full) begin
                            bcnt       <= '0;
                            wr_valid_q <= 1'b1;
                            wr_addr_q  <= addr;
                            wr_data_q  <= shreg;
                            addr       <= {addr[AW-1:PB], addr[PB-1:0] + 1'b1};
                        end
                        ST_WDATA_ACK: bcnt <= '0;
                        ST_RDATA: begin
                            if (byte_full) bcnt <= '0;
                            else           obuf <= {obuf[6:0], 1'b1};
                        end
                        ST_RACK:      bcnt <= '0;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_drive_low = 1'b1;
            ST_RDATA:                               sda_drive_low = ~obuf[7];
            default:                                sda_drive_low = 1'b0;
        endcase
    end

    assign mem_addr = addr;
    assign wr_valid = wr_valid_q;
    assign wr_addr  = wr_addr_q;
    assign wr_data  = wr_data_q;

    p_start_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV && bcnt == 4'd0));

    p_stop_idles_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_drive_low));

    p_busy_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && scl_fall && byte_full && busy && !cond) |=> state == ST_IDLE);

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    p_page_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && scl_fall && byte_full && !cond && addr[PB-1:0] == '1)
        |=> (addr[PB-1:0] == '0 && addr[AW-1:PB] == $past(addr[AW-1:PB])));

    p_read_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load && addr == '1) |=> addr == '0);

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
    parameter int AW         = 11,
    parameter int PAGE_BITS  = 4,
    parameter int SYNC_STAGE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_drive_low,
    input  logic          wr_busy,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    logic          scl_rise, scl_fall, start_det, stop_det, sda_val;
    logic [AW-1:0] mem_addr;
    logic [7:0]    rd_byte;

    tms_line_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_val   (sda_val)
    );

    tms_ctrl #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .sda_val       (sda_val),
        .busy          (wr_busy),
        .rd_byte       (rd_byte),
        .mem_addr      (mem_addr),
        .sda_drive_low (sda_drive_low),
        .wr_valid      (wr_valid),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data)
    );

    tms_regfile #(.AW(AW), .DW(8)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_valid),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (mem_addr),
        .rdata (rd_byte)
    );

endmodule

// File: tb/twi_mem_slave_bench.sv
module twi_mem_slave_bench;
    localparam int AW = 11;
    localparam int Q  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wr_busy = 1'b0;
    logic sda_drive_low, wr_valid;
    logic [AW-1:0] wr_addr;
    logic [7:0] wr_data;
    logic sda_line;

    int nchk = 0;
    int nerr = 0;
    int ref_mem [2048];
    int ref_addr = 0;
    int exp_wa [$];
    int exp_wd [$];
    int wq [$];

    assign sda_line = sda_m & ~sda_drive_low;

    always #4 clk = ~clk;

    twi_mem_slave u_twi_mem_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_m),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low),
        .wr_busy       (wr_busy),
        .wr_valid      (wr_valid),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Per-clock comparison of write strobes against the model (R6)
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_wa.size() == 0) begin
                chk(1'b0, "R6 unexpected write strobe", int'(wr_addr), -1);
            end else begin
                chk(int'(wr_addr) == exp_wa[0] && int'(wr_data) == exp_wd[0],
                    "R6 strobe address/data", int'(wr_addr) * 256 + int'(wr_data),
                    exp_wa[0] * 256 + exp_wd[0]);
                void'(exp_wa.pop_front());
                void'(exp_wd.pop_front());
            end
        end
    end

    task automatic start_c();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(x);
        ack = ~x;
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_in(x);
            d[i] = x;
        end
        bit_out(~master_ack);
    endtask

    task automatic wr_txn(input int page, input int a8);
        bit ack;
        int a;
        start_c();
        send_byte({4'hA, page[2:0], 1'b0}, ack);
        chk(ack, "R3 write header acknowledged", ack, 1);
        send_byte(a8[7:0], ack);
        chk(ack, "R5 word address acknowledged", ack, 1);
        a = page * 256 + a8;
        foreach (wq[k]) begin
            exp_wa.push_back(a);
            exp_wd.push_back(wq[k]);
            ref_mem[a] = wq[k];
            send_byte(wq[k][7:0], ack);
            chk(ack, "R6 data byte acknowledged", ack, 1);
            a = (a & ~15) | ((a + 1) & 15);   // R7 page wrap in model
        end
        ref_addr = a;
        stop_c();
        tick(4 * Q);
        wq.delete();
    endtask

    task automatic rd_cur(input int page, input int n, input string req);
        bit ack;
        logic [7:0] d;
        start_c();
        send_byte({4'hA, page[2:0], 1'b1}, ack);
        chk(ack, "R3 read header acknowledged", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            chk(int'(d) == ref_mem[ref_addr], req, int'(d), ref_mem[ref_addr]);
            ref_addr = (ref_addr + 1) & 2047;
        end
        chk(sda_drive_low == 1'b0, "R9 SDA released after master NACK", sda_drive_low, 0);
        stop_c();
        tick(4 * Q);
    endtask

    task automatic rd_rand(input int page, input int a8, input int n, input string req);
        bit ack;
        start_c();
        send_byte({4'hA, page[2:0], 1'b0}, ack);
        chk(ack, "R10 dummy write header acknowledged", ack, 1);
        send_byte(a8[7:0], ack);
        chk(ack, "R5 random read address acknowledged", ack, 1);
        ref_addr = page * 256 + a8;
        rd_cur(page, n, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        bit ack;
        for (int i = 0; i < 2048; i++) ref_mem[i] = 0;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        // R11 reset state
        chk(sda_drive_low == 1'b0, "R11 SDA released after reset", sda_drive_low, 0);
        chk(wr_valid == 1'b0, "R11 no strobe after reset", wr_valid, 0);
        rd_cur(0, 1, "R11 counter and array cleared");

        // R7 page write that crosses the page end
        wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33); wq.push_back(8'h44);
        wr_txn(3, 8'hFE);
        // R8 / R9 / R10 random sequential read over the wrapped page
        rd_rand(3, 8'hF0, 4, "R9 sequential read data");
        // R10 counter kept; R8 page bits of a read header ignored
        rd_cur(7, 1, "R8 read header page bits ignored");

        // R8 array wrap 0x7FF -> 0x000
        wq.push_back(8'hA5);
        wr_txn(7, 8'hFF);
        wq.push_back(8'h5A); wq.push_back(8'h77); wq.push_back(8'h3C); wq.push_back(8'hC3);
        wr_txn(0, 8'h00);
        rd_rand(7, 8'hFE, 3, "R8 read wraps from 0x7FF to 0x000");

        // R3 header mismatch: no acknowledge, bus ignored
        start_c();
        send_byte(8'h5B, ack);
        chk(!ack, "R3 mismatched header not acknowledged", ack, 0);
        send_byte(8'hFF, ack);
        chk(!ack, "R3 bus ignored after mismatch", ack, 0);
        stop_c();
        tick(4 * Q);
        rd_cur(0, 1, "R10 counter unchanged by mismatch");

        // R4 busy write controller
        wr_busy = 1'b1;
        start_c();
        send_byte(8'hA1, ack);
        chk(!ack, "R4 header not acknowledged while busy", ack, 0);
        stop_c();
        wr_busy = 1'b0;
        tick(4 * Q);
        rd_cur(0, 1, "R4 counter unchanged while busy");

        // R1 START aborts a partial word address
        start_c();
        send_byte(8'hA0, ack);
        chk(ack, "R1 header before abort acknowledged", ack, 1);
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
        rd_cur(0, 1, "R1 partial address discarded by START");

        // R2 STOP in the middle of a data byte
        start_c();
        send_byte(8'hA0, ack);
        chk(ack, "R2 header acknowledged", ack, 1);
        send_byte(8'h00, ack);
        chk(ack, "R2 address acknowledged", ack, 1);
        ref_addr = 0;
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        stop_c();
        tick(4 * Q);
        chk(sda_drive_low == 1'b0, "R2 SDA released after STOP", sda_drive_low, 0);
        rd_cur(0, 1, "R2 partial data byte not stored");

        chk(exp_wa.size() == 0, "R6 all expected strobes seen", exp_wa.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule